// File: doc/BRIEF.md
# EPP Cycle Gate with Timeout

This block is the enhanced-parallel-port engine of a parallel port controller. A host issues register accesses on a simple request/ready bus. Offsets 3 (address) and 4 (data) start byte cycles on the peripheral side, but only when the control register holds the pattern for the requested direction. Offset 4 also takes 16- and 32-bit accesses, which are carried as a run of byte cycles, least significant byte first.

Each peripheral byte cycle raises an address strobe or a data strobe and waits for the peripheral to answer on its wait line. When no answer arrives within a programmable number of cycles, the cycle is abandoned. A sticky timeout flag is then set, and the rest of a wide access is skipped. The host reads the flag in bit 0 of the status register and clears it by writing a 1 to that bit. The block also holds the data and control registers. It reports a change pulse only when a write really alters one of them.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset the control register reads 0xCC, the data register reads 0xFF, the timeout flag is 0, `host_ready` is low and neither strobe is active.
- R2: A write to offset 3 or 4 runs peripheral cycles only if (control AND 0x2F) equals 0x04. Otherwise no strobe occurs and the access still completes.
- R3: A read of offset 3 or 4 runs peripheral cycles only if (control AND 0x2F) equals 0x24. Otherwise no strobe occurs and `host_rdata` is all ones across the access width (byte 0x000000FF, half 0x0000FFFF, word 0xFFFFFFFF).
- R4: Offset 3 uses `per_astb` and offset 4 uses `per_dstb`, never both at once. A write drives the byte on `per_dout` with `per_write` high. A read captures `per_din` in the cycle where `per_wait` is sampled high.
- R5: At offset 4, `host_size` 1 moves 2 bytes and `host_size` 2 moves 4 bytes, least significant byte first. Each byte has its own strobe, with one strobe-free cycle between bytes. Other offsets always move one byte.
- R6: Strobe cycles of a byte are numbered from 0. If `per_wait` has not been sampled high by cycle number `tmo_limit`, the byte aborts, the timeout flag is set, the remaining bytes are skipped, and unread bytes return 0xFF.
- R7: A read of offset 1 returns `per_status_hi` in bits 7..1 and the timeout flag in bit 0.
- R8: The timeout flag is sticky across later successful cycles. A write to offset 1 with bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged.
- R9: A control write (offset 2) stores the value with bits 7..6 forced to 1. A data write (offset 0) stores the value as written. `ctl_chg` and `dat_chg` pulse with `host_ready` only when the stored value changes.
- R10: `host_ready` is a one-cycle pulse. It comes in the cycle after acceptance for register accesses and for EPP accesses that are gated off, and in the cycle after the last byte cycle ends otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held with its operands until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | 0 byte, 1 half, 2 word (offset 4 only) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid while `host_ready` is high |
| host_ready | output | 1 | Access complete pulse |
| tmo_limit | input | 8 | Last strobe cycle number in which the answer is accepted |
| per_status_hi | input | 7 | Peripheral status lines for status bits 7..1 |
| per_din | input | 8 | Peripheral read data |
| per_wait | input | 1 | Peripheral answer handshake |
| per_dout | output | 8 | Peripheral write data |
| per_write | output | 1 | High during strobes of a write cycle |
| per_astb | output | 1 | Address strobe |
| per_dstb | output | 1 | Data strobe |
| ctl_out | output | 8 | Control register value |
| dat_out | output | 8 | Data register value |
| ctl_chg | output | 1 | Control register changed pulse |
| dat_chg | output | 8 == 8 ? 1 : 1 | Data register changed pulse |

## Verification
A register access or a gated-off EPP access is due one clock edge after acceptance. For a byte cycle that succeeds, the result is due one edge after the edge where `per_wait` is sampled high, and each later byte adds a strobe-free cycle. An abandoned byte ends at the edge that closes strobe cycle `tmo_limit`, so a failing access finishes `tmo_limit`+2 edges after acceptance. The bench counts edges from acceptance to `host_ready`, samples every result on the falling edge while `host_ready` is high, and checks these counts directly for the register, wide-write and timeout cases. The peripheral model answers after a set number of cycles, so both the last accepted cycle and the first failing cycle of the timeout window are exercised.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam logic [7:0] CTL_GATE_MASK  = 8'h2F;
  localparam logic [7:0] CTL_WR_PATTERN = 8'h04;
  localparam logic [7:0] CTL_RD_PATTERN = 8'h24;
  localparam logic [7:0] CTL_FIXED_ONES = 8'hC0;
  localparam logic [7:0] CTL_RESET      = 8'hCC;
  localparam logic [7:0] DAT_RESET      = 8'hFF;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_EADR = 3'd3;
  localparam logic [2:0] OFS_EDAT = 3'd4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_STB, SQ_GAP, SQ_DONE} sq_state_t;
endpackage

// File: rtl/epp_gate.sv
// Decodes whether an access targets the EPP offsets, whether the control
// pattern permits it, and how many byte cycles it needs.
module epp_gate
  import epp_gate_pkg::*;
#(
  parameter int HOST_BYTES = 4,
  parameter int NB_W       = 2
) (
  input  logic [7:0]      ctl,
  input  logic [2:0]      addr,
  input  logic            we,
  input  logic [1:0]      size,
  output logic            is_epp,
  output logic            permit,
  output logic [NB_W-1:0] nb_m1
);
  logic [7:0]  masked;
  int unsigned want;

  always_comb begin
    is_epp = (addr == OFS_EADR) || (addr == OFS_EDAT);
    masked = ctl & CTL_GATE_MASK;
    permit = we ? (masked == CTL_WR_PATTERN) : (masked == CTL_RD_PATTERN);
    want   = 1;
    if (addr == OFS_EDAT) begin
      want = 32'd1 << size;
      if (want > HOST_BYTES) want = HOST_BYTES;
    end
    nb_m1 = NB_W'(want - 1);
  end
endmodule

// File: rtl/epp_regs.sv
// Data, control and sticky timeout flag, plus the register read byte.
module epp_regs
  import epp_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_acc,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wbyte,
  input  logic       fail,
  input  logic [6:0] per_status_hi,
  output logic [7:0] ctl_q,
  output logic [7:0] dat_q,
  output logic       tmo_q,
  output logic       ctl_chg,
  output logic       dat_chg,
  output logic [7:0] rbyte
);
  logic [7:0] ctl_d, dat_d, ctl_new;
  logic       tmo_d, ctl_chg_d, dat_chg_d, wr, clr;

  always_comb begin
    wr        = reg_acc && we;
    ctl_new   = wbyte | CTL_FIXED_ONES;
    ctl_chg_d = wr && (addr == OFS_CTL)  && (ctl_new != ctl_q);
    dat_chg_d = wr && (addr == OFS_DATA) && (wbyte != dat_q);
    ctl_d     = ctl_chg_d ? ctl_new : ctl_q;
    dat_d     = dat_chg_d ? wbyte : dat_q;
    clr       = wr && (addr == OFS_STAT) && wbyte[0];
    if (fail)     tmo_d = 1'b1;
    else if (clr) tmo_d = 1'b0;
    else          tmo_d = tmo_q;
    case (addr)
      OFS_DATA: rbyte = dat_q;
      OFS_STAT: rbyte = {per_status_hi, tmo_q};
      OFS_CTL:  rbyte = ctl_q;
      default:  rbyte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RESET;
      dat_q   <= DAT_RESET;
      tmo_q   <= 1'b0;
      ctl_chg <= 1'b0;
      dat_chg <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      dat_q   <= dat_d;
      tmo_q   <= tmo_d;
      ctl_chg <= ctl_chg_d;
      dat_chg <= dat_chg_d;
    end
  end

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> tmo_q);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_acc && we && addr == OFS_STAT && wbyte[0] && !fail) |=> !tmo_q);
  p_ctl_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7:6] == 2'b11);
  p_ctl_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_chg |-> (ctl_q != $past(ctl_q)));
endmodule

// File: rtl/epp_seq.sv
// Host access sequencer: accepts a request, runs the byte cycles with
// their timeout counter, and produces the ready pulse.
module epp_seq
  import epp_gate_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int NB_W   = 2,
  parameter int TW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic              is_epp,
  input  logic              permit,
  input  logic [NB_W-1:0]   nb_m1,
  input  logic [HOST_W-1:0] wdata,
  input  logic [TW-1:0]     tmo_limit,
  input  logic              per_wait,
  input  logic [7:0]        per_din,
  output logic              reg_acc,
  output logic              ready,
  output logic              fail,
  output logic              epp_q,
  output logic [NB_W-1:0]   nb_q,
  output logic [HOST_W-1:0] buf_q,
  output logic              per_astb,
  output logic              per_dstb,
  output logic              per_write,
  output logic [7:0]        per_dout
);
  sq_state_t         st_q, st_d;
  logic [NB_W-1:0]   bidx_q, bidx_d, nb_d;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic [HOST_W-1:0] buf_d;
  logic              rd_q, rd_d, adr_q, adr_d, epp_d;

  always_comb begin
    st_d    = st_q;
    bidx_d  = bidx_q;
    cnt_d   = cnt_q;
    buf_d   = buf_q;
    nb_d    = nb_q;
    rd_d    = rd_q;
    adr_d   = adr_q;
    epp_d   = epp_q;
    fail    = 1'b0;
    reg_acc = 1'b0;
    case (st_q)
      SQ_IDLE: if (req) begin
        nb_d    = is_epp ? nb_m1 : '0;
        rd_d    = !we;
        adr_d   = (addr == OFS_EADR);
        epp_d   = is_epp;
        bidx_d  = '0;
        cnt_d   = '0;
        buf_d   = we ? wdata : '1;
        reg_acc = !is_epp;
        st_d    = (is_epp && permit) ? SQ_STB : SQ_DONE;
      end
      SQ_STB: begin
        if (per_wait) begin
          if (rd_q) buf_d[{bidx_q, 3'b000} +: 8] = per_din;
          if (bidx_q == nb_q) begin
            st_d = SQ_DONE;
          end else begin
            bidx_d = bidx_q + NB_W'(1);
            cnt_d  = '0;
            st_d   = SQ_GAP;
          end
        end else if (cnt_q >= tmo_limit) begin
          fail = 1'b1;
          st_d = SQ_DONE;
        end else begin
          cnt_d = cnt_q + TW'(1);
        end
      end
      SQ_GAP:  st_d = SQ_STB;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      bidx_q <= '0;
      cnt_q  <= '0;
      buf_q  <= '1;
      nb_q   <= '0;
      rd_q   <= 1'b1;
      adr_q  <= 1'b0;
      epp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bidx_q <= bidx_d;
      cnt_q  <= cnt_d;
      buf_q  <= buf_d;
      nb_q   <= nb_d;
      rd_q   <= rd_d;
      adr_q  <= adr_d;
      epp_q  <= epp_d;
    end
  end

  always_comb begin
    ready     = (st_q == SQ_DONE);
    per_astb  = (st_q == SQ_STB) && adr_q;
    per_dstb  = (st_q == SQ_STB) && !adr_q;
    per_write = (st_q == SQ_STB) && !rd_q;
    per_dout  = buf_q[{bidx_q, 3'b000} +: 8];
  end

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_astb, per_dstb}));
  p_strobe_epp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_astb || per_dstb) |-> epp_q);
  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_fail_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> (ready && !per_astb && !per_dstb));
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int TW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [1:0]        host_size,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_ready,
  input  logic [TW-1:0]     tmo_limit,
  input  logic [6:0]        per_status_hi,
  input  logic [7:0]        per_din,
  input  logic              per_wait,
  output logic [7:0]        per_dout,
  output logic              per_write,
  output logic              per_astb,
  output logic              per_dstb,
  output logic [7:0]        ctl_out,
  output logic [7:0]        dat_out,
  output logic              ctl_chg,
  output logic              dat_chg
);
  localparam int HOST_BYTES = HOST_W / 8;
  localparam int NB_W       = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1;

  // reset asserts at once, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic              is_epp, permit, reg_acc, fail, tmo_q, epp_q;
  logic [NB_W-1:0]   nb_m1, nb_q;
  logic [HOST_W-1:0] buf_q, mask;
  logic [7:0]        rbyte;

  epp_gate #(.HOST_BYTES(HOST_BYTES), .NB_W(NB_W)) u_gate (
    .ctl(ctl_out), .addr(host_addr), .we(host_we), .size(host_size),
    .is_epp(is_epp), .permit(permit), .nb_m1(nb_m1)
  );

  epp_seq #(.HOST_W(HOST_W), .NB_W(NB_W), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_ni), .req(host_req), .we(host_we),
    .addr(host_addr), .is_epp(is_epp), .permit(permit), .nb_m1(nb_m1),
    .wdata(host_wdata), .tmo_limit(tmo_limit), .per_wait(per_wait),
    .per_din(per_din), .reg_acc(reg_acc), .ready(host_ready), .fail(fail),
    .epp_q(epp_q), .nb_q(nb_q), .buf_q(buf_q), .per_astb(per_astb),
    .per_dstb(per_dstb), .per_write(per_write), .per_dout(per_dout)
  );

  epp_regs u_regs (
    .clk(clk), .rst_n(rst_ni), .reg_acc(reg_acc), .we(host_we),
    .addr(host_addr), .wbyte(host_wdata[7:0]), .fail(fail),
    .per_status_hi(per_status_hi), .ctl_q(ctl_out), .dat_q(dat_out),
    .tmo_q(tmo_q), .ctl_chg(ctl_chg), .dat_chg(dat_chg), .rbyte(rbyte)
  );

  for (genvar b = 0; b < HOST_BYTES; b++) begin : g_mask
    assign mask[b*8 +: 8] = (NB_W'(b) <= nb_q) ? 8'hFF : 8'h00;
  end

  assign host_rdata = epp_q ? (buf_q & mask) : {{(HOST_W-8){1'b0}}, rbyte};

  p_gate_write_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    ((per_astb || per_dstb) && per_write) |-> ((ctl_out & CTL_GATE_MASK) == CTL_WR_PATTERN));
  p_gate_read_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    ((per_astb || per_dstb) && !per_write) |-> ((ctl_out & CTL_GATE_MASK) == CTL_RD_PATTERN));
  p_chg_with_ready_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_chg || dat_chg) |-> host_ready);
endmodule

// File: tb/sim_epp_cycle_gate.sv
`timescale 1ns/1ps
module sim_epp_cycle_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ready;
  logic [7:0]  tmo_limit = 8'd4;
  logic [6:0]  per_status_hi = 7'h2D;   // status reads 0x5A with flag clear
  logic [7:0]  per_din;
  logic        per_wait;
  logic [7:0]  per_dout, ctl_out, dat_out;
  logic        per_write, per_astb, per_dstb, ctl_chg, dat_chg;

  always #2 clk = ~clk;

  epp_cycle_gate u0 (.*);

  // peripheral model: answers dly posedges after it first sees a strobe
  logic        op_start = 1'b1;
  logic [7:0]  dly = 8'd0, din_base = 8'd0;
  logic        w = 1'b0, pa = 1'b0, pd = 1'b0;
  int          bcnt = 0, bi = 0, wi = 0, na = 0, nd = 0;
  logic [31:0] pack = '0;

  assign per_wait = w;
  assign per_din  = din_base + 8'(bi);

  always @(posedge clk) begin
    if (op_start) begin
      bcnt <= 0; bi <= 0; wi <= 0; w <= 1'b0; pack <= '0; na <= 0; nd <= 0;
    end else begin
      if (per_astb && !pa) na <= na + 1;
      if (per_dstb && !pd) nd <= nd + 1;
      if (!(per_astb || per_dstb)) begin
        if (w) bi <= bi + 1;
        w <= 1'b0; bcnt <= 0;
      end else if (!w) begin
        if (bcnt == int'(dly)) begin
          w <= 1'b1;
          if (per_write) begin pack[wi*8 +: 8] <= per_dout; wi <= wi + 1; end
        end else bcnt <= bcnt + 1;
      end
    end
    pa <= per_astb; pd <= per_dstb;
  end

  int nchk = 0, nfail = 0, edges = 0;
  logic got_ready;
  logic [31:0] rd_v;
  logic [1:0]  chg_v;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [2:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [7:0] d, input logic [7:0] db);
    @(negedge clk);
    op_start = 1'b1; dly = d; din_base = db;
    @(negedge clk);
    op_start = 1'b0;
    host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
    edges = 0; got_ready = 1'b0;
    while (!got_ready && edges < 1000) begin
      @(posedge clk); edges++;
      @(negedge clk);
      got_ready = host_ready;
    end
    if (!got_ready) check("R10 watchdog", 32'd0, 32'd1);
    rd_v = host_rdata; chg_v = {ctl_chg, dat_chg};
    host_req = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [7:0]  dly;
    logic [7:0]  din;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic [3:0]  exp_a;
    logic [3:0]  exp_d;
    logic        chk_pk;
    logic [31:0] exp_pk;
    logic [1:0]  exp_chg;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{1,3,0,32'h5A,0,0,        0,32'h0,       0,0,1,32'h0,      2'b00,2},  // R2 gated off
    '{0,4,2,32'h0,0,0,         1,32'hFFFFFFFF,0,0,0,32'h0,      2'b00,3},  // R3 word ones
    '{0,4,1,32'h0,0,0,         1,32'h0000FFFF,0,0,0,32'h0,      2'b00,3},  // R3 half ones
    '{1,2,0,32'h04,0,0,        0,32'h0,       0,0,0,32'h0,      2'b10,9},  // R9 ctl write
    '{0,2,0,32'h0,0,0,         1,32'hC4,      0,0,0,32'h0,      2'b00,9},  // R9 ctl read
    '{1,3,0,32'h3C,1,0,        0,32'h0,       1,0,1,32'h3C,     2'b00,4},  // R4 addr write
    '{1,4,2,32'h44332211,0,0,  0,32'h0,       0,4,1,32'h44332211,2'b00,5}, // R5 word write
    '{1,4,1,32'h0000BEEF,2,0,  0,32'h0,       0,2,1,32'hBEEF,   2'b00,5},  // R5 half write
    '{0,4,0,32'h0,0,0,         1,32'hFF,      0,0,0,32'h0,      2'b00,3},  // R3 byte ones
    '{1,2,0,32'h24,0,0,        0,32'h0,       0,0,0,32'h0,      2'b10,9},  // R9
    '{0,4,2,32'h0,0,8'h10,     1,32'h13121110,0,4,0,32'h0,      2'b00,5},  // R5 word read
    '{0,3,0,32'h0,0,8'h10,     1,32'h10,      1,0,0,32'h0,      2'b00,4},  // R4 addr read
    '{1,4,0,32'h77,0,0,        0,32'h0,       0,0,1,32'h0,      2'b00,2},  // R2 write in read mode
    '{0,4,1,32'h0,4,8'h10,     1,32'h0000FFFF,0,1,0,32'h0,      2'b00,6},  // R6 abort, skip
    '{0,1,0,32'h0,0,0,         1,32'h5B,      0,0,0,32'h0,      2'b00,7},  // R7 flag seen
    '{0,4,0,32'h0,3,8'h10,     1,32'h10,      0,1,0,32'h0,      2'b00,6},  // R6 last cycle ok
    '{0,1,0,32'h0,0,0,         1,32'h5B,      0,0,0,32'h0,      2'b00,8},  // R8 sticky
    '{1,1,0,32'h00,0,0,        0,32'h0,       0,0,0,32'h0,      2'b00,8},  // R8 bit0=0
    '{0,1,0,32'h0,0,0,         1,32'h5B,      0,0,0,32'h0,      2'b00,8},  // R8
    '{1,1,0,32'h01,0,0,        0,32'h0,       0,0,0,32'h0,      2'b00,8},  // R8 clear
    '{0,1,0,32'h0,0,0,         1,32'h5A,      0,0,0,32'h0,      2'b00,8},  // R8
    '{1,2,0,32'h24,0,0,        0,32'h0,       0,0,0,32'h0,      2'b00,9},  // R9 same ctl
    '{1,0,0,32'hFF,0,0,        0,32'h0,       0,0,0,32'h0,      2'b00,9},  // R9 same data
    '{1,0,0,32'h81,0,0,        0,32'h0,       0,0,0,32'h0,      2'b01,9},  // R9 data change
    '{0,0,0,32'h0,0,0,         1,32'h81,      0,0,0,32'h0,      2'b00,9},  // R9 data read
    '{1,2,0,32'hE4,0,0,        0,32'h0,       0,0,0,32'h0,      2'b00,9}   // R9 bits 7..6
  };

  initial begin
    #800000;
    nfail++; nchk++;
    $display("FAIL R10 global watchdog actual=running expected=finished");
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready", {31'd0, host_ready}, 32'd0);
    check("R1 strobes", {30'd0, per_astb, per_dstb}, 32'd0);
    check("R1 ctl", {24'd0, ctl_out}, 32'hCC);
    check("R1 dat", {24'd0, dat_out}, 32'hFF);
    do_op(0, 1, 0, 0, 0, 0);
    check("R1 status flag", rd_v, 32'h5A);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", TBL[i].rq, i);
      do_op(TBL[i].we, TBL[i].addr, TBL[i].size, TBL[i].wdata, TBL[i].dly, TBL[i].din);
      if (TBL[i].chk_rd) check({rq, " rdata"}, rd_v, TBL[i].exp_rd);
      check({rq, " astb"}, 32'(na), {28'd0, TBL[i].exp_a});
      check({rq, " dstb"}, 32'(nd), {28'd0, TBL[i].exp_d});
      if (TBL[i].chk_pk) check({rq, " bytes"}, pack, TBL[i].exp_pk);
      check({rq, " chg"}, {30'd0, chg_v}, {30'd0, TBL[i].exp_chg});
    end

    // R10: register access timing and single-cycle ready
    do_op(0, 2, 0, 0, 0, 0);
    check("R10 reg latency", 32'(edges), 32'd1);
    @(negedge clk);
    check("R10 ready pulse", {31'd0, host_ready}, 32'd0);
    do_op(1, 2, 0, 32'h04, 0, 0);
    // R5 / R10: word write, answer after 0 cycles: 4*(2)+3 gaps+1 accept
    do_op(1, 4, 2, 32'hCAFE0102, 0, 0);
    check("R10 word latency", 32'(edges), 32'd12);
    check("R5 word order", pack, 32'hCAFE0102);
    // R6: no answer at all, limit 4
    do_op(1, 4, 2, 32'h0, 8'hFF, 0);
    check("R6 timeout latency", 32'(edges), 32'd6);
    check("R6 skipped bytes", 32'(nd), 32'd1);
    do_op(0, 1, 0, 0, 0, 0);
    check("R6 flag set", rd_v, 32'h5B);
    do_op(1, 1, 0, 32'h01, 0, 0);
    // R6 window boundary at limit 1
    tmo_limit = 8'd1;
    do_op(1, 3, 0, 32'h11, 0, 0);
    do_op(0, 1, 0, 0, 0, 0);
    check("R6 limit1 ok", rd_v, 32'h5A);
    do_op(1, 3, 0, 32'h12, 1, 0);
    do_op(0, 1, 0, 0, 0, 0);
    check("R6 limit1 fail", rd_v, 32'h5B);
    // R1: reset in service clears flag and registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 ctl on reset", {24'd0, ctl_out}, 32'hCC);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_op(0, 1, 0, 0, 0, 0);
    check("R1 flag after reset", rd_v, 32'h5A);
    do_op(0, 0, 0, 0, 0, 0);
    check("R1 dat after reset", rd_v, 32'hFF);

    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule